// File: doc/BRIEF.md
# Iterative 512-bit Byte-Matrix Permutation Core

This block computes one of two fixed, keyless permutations of a 512-bit state arranged as an 8 by 8 matrix of bytes. A select input chooses between the two variants, called P and Q here. Both variants share one round datapath. Each round applies four steps in a fixed order: a round-dependent constant XOR, the AES byte substitution on all 64 bytes, a rotation of each row, and a column mixing step over GF(2^8). The two variants differ only in the constant and in the rotation amounts.

The core runs ten rounds, one per clock. A start pulse while idle captures the input state and the select. `busy_o` then stays high until the last round is written, and `done_o` pulses for one cycle when `result_o` holds the finished permutation. The result stays on `result_o` until the next accepted start. The core is meant to sit inside a hashing engine, which does the padding, chaining and output stages.

Top module: `wperm_core`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `done_o` and `result_o` are all zero.
- R2: A `start_i` pulse while `busy_o` is low captures `state_i` and `use_q_i` at that clock edge, and `busy_o` is high in the next cycle.
- R3: `done_o` is high for exactly one cycle, 10 cycles after the load edge. `busy_o` falls in the same cycle that `done_o` rises.
- R4: Byte (row r, column c) of `state_i` and of `result_o` occupies bits [511-8*(8c+r) -: 8]. Byte (0,0) is the most significant, and consecutive bytes run down a column.
- R5: Round k (k = 0..9) first XORs the constant. For P (`use_q_i`=0), only row 0 is changed: byte (0,c) is XORed with {c[3:0], k[3:0]}.
- R6: For Q (`use_q_i`=1), every byte of rows 0 to 6 is XORed with 0xFF, and byte (7,c) is XORed with {(15-c)[3:0], k[3:0]}.
- R7: After the constant, every byte x is replaced by the AES S-box value: the inverse of x in GF(2^8) modulo 0x11B (0 maps to 0), followed by y ^ rotl(y,1) ^ rotl(y,2) ^ rotl(y,3) ^ rotl(y,4) ^ 0x63.
- R8: Row r is then rotated left by s positions, so new (r,c) takes old (r,(c+s) mod 8). For P, s = r. For Q, s for rows 0 to 7 is 1, 3, 5, 7, 0, 2, 4, 6.
- R9: Each column a is then replaced by b, where b_i = XOR over j of m((j-i) mod 8) * a_j in GF(2^8) modulo 0x11B, and m(0..7) = 2, 2, 3, 4, 5, 3, 5, 7.
- R10: A `start_i` received while `busy_o` is high is ignored. A change of `use_q_i` after the load does not change the running computation.
- R11: While idle and without a start, `result_o` holds its last value and `done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only while idle |
| use_q_i | input | 1 | Variant select at load: 0 = P, 1 = Q |
| state_i | input | 512 | Input state, byte layout per R4 |
| busy_o | output | 1 | High from load until the last round |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| result_o | output | 512 | Permuted state, layout per R4 |

## Verification
Every result is compared with a behavioural model written separately in the bench, which builds its S-box by searching for inverses. The all-zero input is run through both variants; it isolates the constant and rotation differences between P and Q, because the substitution then acts on constants alone. The all-ones and column-repeating inputs expose swapped rows or columns in the rotation and mixing. Single-byte inputs at opposite corners of the matrix pin down the byte layout. Random states in both variants cover the general datapath, and a restart attempted mid-run, combined with a select that toggles, shows that the loaded variant is kept.

// File: rtl/wperm_pkg.sv
// Shared constants and GF(2^8) helpers for the byte-matrix permutation core.
// Assumes an 8x8 byte state and the field polynomial 0x11B.
package wperm_pkg;
    localparam int ROWS    = 8;
    localparam int COLS    = 8;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = ROWS * COLS;
    localparam int STATE_W = NBYTES * BYTE_W;
    localparam int COL_W   = ROWS * BYTE_W;
    localparam int CNST_W  = 4;

    typedef logic [BYTE_W-1:0] gf8_t;

    // Circulant coefficients of the column mixing, by (j - i) mod 8
    localparam gf8_t MIX_COEF [COLS] = '{8'h02, 8'h02, 8'h03, 8'h04,
                                         8'h05, 8'h03, 8'h05, 8'h07};

    // Lowest bit index of byte (r, c) inside the packed state
    function automatic int byte_lsb(input int r, input int c);
        return STATE_W - BYTE_W * (COLS * c + r + 1);
    endfunction

    // Multiply by x modulo 0x11B
    function automatic gf8_t gf_xtime(input gf8_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General field multiply by shift-and-add
    function automatic gf8_t gf_mul(input gf8_t a, input gf8_t b);
        gf8_t acc = 8'h00;
        gf8_t t   = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ t;
            t = gf_xtime(t);
        end
        return acc;
    endfunction

    // Inverse as x^254 via an addition chain; maps 0 to 0
    function automatic gf8_t gf_inv(input gf8_t x);
        gf8_t x2, x3, x6, x12, x15, x30, x60, x120, x240, x252;
        x2   = gf_mul(x, x);
        x3   = gf_mul(x2, x);
        x6   = gf_mul(x3, x3);
        x12  = gf_mul(x6, x6);
        x15  = gf_mul(x12, x3);
        x30  = gf_mul(x15, x15);
        x60  = gf_mul(x30, x30);
        x120 = gf_mul(x60, x60);
        x240 = gf_mul(x120, x120);
        x252 = gf_mul(x240, x12);
        return gf_mul(x252, x2);
    endfunction

    // Byte substitution: field inverse then affine map
    function automatic gf8_t sub_byte(input gf8_t x);
        gf8_t y = gf_inv(x);
        return y ^ {y[6:0], y[7]} ^ {y[5:0], y[7:6]} ^ {y[4:0], y[7:5]}
                 ^ {y[3:0], y[7:4]} ^ 8'h63;
    endfunction

    // Left-rotation amount of row r for either variant
    function automatic int row_shift(input bit use_q, input int r);
        if (!use_q) return r;
        case (r)
            0: return 1;
            1: return 3;
            2: return 5;
            3: return 7;
            4: return 0;
            5: return 2;
            6: return 4;
            default: return 6;
        endcase
    endfunction
endpackage

// File: rtl/wperm_mixcol.sv
// Column mixing of one 8-byte column by the fixed circulant matrix.
// Assumes row r of the column sits at bits [8r +: 8]. Purely combinational.
module wperm_mixcol
    import wperm_pkg::*;
(
    input  logic [COL_W-1:0] col_i,
    output logic [COL_W-1:0] col_o
);
    // Each output byte is the XOR of all input bytes scaled by its coefficient
    always_comb begin
        for (int i = 0; i < ROWS; i++) begin
            gf8_t acc;
            acc = 8'h00;
            for (int j = 0; j < ROWS; j++) begin
                acc = acc ^ gf_mul(MIX_COEF[(j - i + ROWS) % ROWS], col_i[j*BYTE_W +: BYTE_W]);
            end
            col_o[i*BYTE_W +: BYTE_W] = acc;
        end
    end
endmodule

// File: rtl/wperm_round.sv
// One complete round: constant XOR, byte substitution, row rotation and
// column mixing. The select only steers the constant and the rotation.
// Assumes the round number fits in CNST_W bits. Purely combinational.
module wperm_round
    import wperm_pkg::*;
(
    input  logic [STATE_W-1:0] state_i,
    input  logic [CNST_W-1:0]  rnd_i,
    input  logic               use_q_i,
    output logic [STATE_W-1:0] state_o
);
    gf8_t             sub_m   [ROWS][COLS];
    logic [COL_W-1:0] shf_col [COLS];
    logic [COL_W-1:0] mix_col [COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            localparam int LSB = byte_lsb(r, c);
            localparam int SP  = (c + row_shift(1'b0, r)) % COLS;
            localparam int SQ  = (c + row_shift(1'b1, r)) % COLS;
            gf8_t cst_p, cst_q;
            // Constant of each variant for this byte position
            assign cst_p = (r == 0) ? {CNST_W'(c), rnd_i} : 8'h00;
            assign cst_q = (r == ROWS - 1) ? {CNST_W'(COLS * 2 - 1 - c), rnd_i} : 8'hff;
            // Substitute after the selected constant
            assign sub_m[r][c] = sub_byte(state_i[LSB +: BYTE_W] ^ (use_q_i ? cst_q : cst_p));
            // Row rotation picks the source column per variant
            assign shf_col[c][r*BYTE_W +: BYTE_W] = use_q_i ? sub_m[r][SQ] : sub_m[r][SP];
            // Scatter the mixed column back into the state layout
            assign state_o[LSB +: BYTE_W] = mix_col[c][r*BYTE_W +: BYTE_W];
        end
        wperm_mixcol u_mix (
            .col_i (shf_col[c]),
            .col_o (mix_col[c])
        );
    end
endmodule

// File: rtl/wperm_core.sv
// Iterative permutation core: loads a 512-bit state on an idle start, then
// applies ROUNDS rounds, one per clock, and pulses done. Assumes ROUNDS <= 16
// so that the round number fits in the constant nibble.
module wperm_core
    import wperm_pkg::*;
#(
    parameter int ROUNDS = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               use_q_i,
    input  logic [STATE_W-1:0] state_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [STATE_W-1:0] result_o
);
    localparam int              RND_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam logic [RND_W-1:0] LAST = RND_W'(ROUNDS - 1);

    logic [STATE_W-1:0] state_q, state_nxt;
    logic [RND_W-1:0]   rnd_q;
    logic               sel_q, busy_q, done_q;

    wperm_round u_round (
        .state_i (state_q),
        .rnd_i   (CNST_W'(rnd_q)),
        .use_q_i (sel_q),
        .state_o (state_nxt)
    );

    // Load on idle start, iterate while busy, pulse done after the last round
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            rnd_q   <= '0;
            sel_q   <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    state_q <= state_i;
                    sel_q   <= use_q_i;
                    rnd_q   <= '0;
                    busy_q  <= 1'b1;
                end
            end else begin
                state_q <= state_nxt;
                rnd_q   <= rnd_q + 1'b1;
                if (rnd_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o   = busy_q;
    assign done_o   = done_q;
    assign result_o = state_q;
endmodule

// File: rtl/wperm_core_chk.sv
// Protocol checker for wperm_core: load, round progress, done timing and
// result hold. Counts cycles since load itself rather than using long delays.
module wperm_core_chk
    import wperm_pkg::*;
#(
    parameter int ROUNDS = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [STATE_W-1:0] result_o,
    input logic               sel_q,
    input logic [((ROUNDS > 1) ? $clog2(ROUNDS) : 1)-1:0] rnd_q
);
    localparam int              RND_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam int              CW    = $clog2(ROUNDS + 2);
    localparam logic [RND_W-1:0] LAST = RND_W'(ROUNDS - 1);

    logic [CW-1:0] win_q;

    // Cycles elapsed since the last accepted load
    always_ff @(posedge clk) begin
        if (!rst_n)                  win_q <= '0;
        else if (start_i && !busy_o) win_q <= '0;
        else if (busy_o)             win_q <= win_q + 1'b1;
    end

    AST_LOAD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R2
    AST_DONE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (win_q == CW'(ROUNDS))); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R3
    AST_RUN_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && rnd_q != LAST) |=> (busy_o && rnd_q == $past(rnd_q) + 1'b1)); // R10
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(sel_q)); // R10
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(result_o) && !done_o)); // R11
endmodule

bind wperm_core wperm_core_chk #(.ROUNDS(ROUNDS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o),
    .sel_q    (sel_q),
    .rnd_q    (rnd_q)
);

// File: tb/wperm_core_tb_top.sv
// Self-checking bench for wperm_core with an independent behavioural model.
module wperm_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    localparam logic [511:0] VEC_STATE [NVEC] = '{
        512'h0,
        512'h0,
        {512{1'b1}},
        {8{64'h0001020304050607}},
        512'h1,
        {1'b1, 511'b0}
    };
    localparam logic VEC_SEL [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_d = 1'b0;
    logic         sel_d = 1'b0;
    logic [511:0] state_d = '0;
    logic         busy_o, done_o;
    logic [511:0] result_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] sb_t [256];

    always #(CLK_PERIOD / 2) clk = ~clk;

    wperm_core dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_d),
        .use_q_i  (sel_d),
        .state_i  (state_d),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .result_o (result_o)
    );

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11b << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [511:0] model_perm(input logic [511:0] v, input logic q);
        logic [7:0] a [8][8];
        logic [7:0] b [8][8];
        int sq [8] = '{1, 3, 5, 7, 0, 2, 4, 6};
        int mc [8] = '{2, 2, 3, 4, 5, 3, 5, 7};
        logic [511:0] o;
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 8; r++) a[r][c] = v[511 - 8*(8*c + r) -: 8];
        for (int k = 0; k < 10; k++) begin
            for (int r = 0; r < 8; r++)
                for (int c = 0; c < 8; c++) begin
                    if (!q) begin
                        if (r == 0) a[r][c] = a[r][c] ^ {4'(c), 4'(k)};
                    end else begin
                        if (r < 7) a[r][c] = a[r][c] ^ 8'hff;
                        else       a[r][c] = a[r][c] ^ {4'(15 - c), 4'(k)};
                    end
                    a[r][c] = sb_t[a[r][c]];
                end
            for (int r = 0; r < 8; r++)
                for (int c = 0; c < 8; c++) b[r][c] = a[r][(c + (q ? sq[r] : r)) % 8];
            for (int c = 0; c < 8; c++)
                for (int i = 0; i < 8; i++) begin
                    a[i][c] = 8'h00;
                    for (int j = 0; j < 8; j++)
                        a[i][c] = a[i][c] ^ m_mul(8'(mc[(j - i + 8) % 8]), b[j][c]);
                end
        end
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 8; r++) o[511 - 8*(8*c + r) -: 8] = a[r][c];
        return o;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [511:0] act, input logic [511:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    // Run one permutation and check busy, latency, idle state and the result
    task automatic run_vec(input logic [511:0] v, input logic q, input string tag);
        logic [511:0] exp_v;
        int lat;
        exp_v = model_perm(v, q);
        @(negedge clk);
        state_d = v; sel_d = q; start_d = 1'b1;
        @(negedge clk);
        start_d = 1'b0;
        chk(busy_o == 1'b1, {"R2 busy after load ", tag}, 512'(busy_o), 512'd1);
        lat = 0;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 10, {"R3 done latency ", tag}, 512'(lat), 512'd10);
        chk(busy_o == 1'b0, {"R3 busy low at done ", tag}, 512'(busy_o), 512'd0);
        chk(result_o == exp_v, {q ? "R4 R6 R7 R8 R9 result Q " : "R4 R5 R7 R8 R9 result P ", tag},
            result_o, exp_v);
    endtask

    initial begin
        logic [511:0] rv, exp_v, held;
        int lat;
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv, y;
            inv = 8'h00;
            for (int z = 1; z < 256; z++) if (m_mul(8'(x), 8'(z)) == 8'h01) inv = 8'(z);
            y = inv;
            sb_t[x] = y ^ {y[6:0], y[7]} ^ {y[5:0], y[7:6]} ^ {y[4:0], y[7:5]} ^ {y[3:0], y[7:4]} ^ 8'h63;
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R1 busy after reset", 512'(busy_o), 512'd0);
        chk(done_o == 1'b0, "R1 done after reset", 512'(done_o), 512'd0);
        chk(result_o == '0, "R1 result after reset", result_o, 512'd0);
        rst_n = 1'b1;

        // Table of directed vectors
        for (int i = 0; i < NVEC; i++) run_vec(VEC_STATE[i], VEC_SEL[i], $sformatf("vec%0d", i));

        // Random states in both variants
        for (int n = 0; n < 6; n++) begin
            for (int w = 0; w < 16; w++) rv[w*32 +: 32] = $urandom;
            run_vec(rv, n[0], $sformatf("rand%0d", n));
        end

        // R10: restart and select change during a run have no effect
        for (int w = 0; w < 16; w++) rv[w*32 +: 32] = $urandom;
        exp_v = model_perm(rv, 1'b0);
        @(negedge clk);
        state_d = rv; sel_d = 1'b0; start_d = 1'b1;
        @(negedge clk);
        start_d = 1'b0;
        repeat (2) @(negedge clk);
        state_d = ~rv; sel_d = 1'b1; start_d = 1'b1;
        @(negedge clk);
        start_d = 1'b0;
        lat = 3;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 10, "R10 latency unchanged by mid-run start", 512'(lat), 512'd10);
        chk(result_o == exp_v, "R10 result keeps loaded data and select", result_o, exp_v);

        // R11: result held while idle
        held = result_o;
        state_d = 512'h5a; sel_d = 1'b0;
        repeat (5) @(negedge clk);
        chk(result_o == held, "R11 result held while idle", result_o, held);
        chk(done_o == 1'b0, "R11 done stays low while idle", 512'(done_o), 512'd0);

        // R1: reset during a run returns to idle zero state
        @(negedge clk);
        state_d = rv; start_d = 1'b1;
        @(negedge clk);
        start_d = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 busy after mid-run reset", 512'(busy_o), 512'd0);
        chk(result_o == '0, "R1 result after mid-run reset", result_o, 512'd0);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog ends a hung run as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule